// File: doc/BRIEF.md
# Dual-Mode 8-bit PWM Timer

This block is an 8-bit timer that drives two pulse-width outputs, A and B, from a single counter. The counter either climbs from zero to its ceiling and wraps (single-slope, fast PWM), or climbs to the ceiling and falls back to zero (dual-slope, phase-correct PWM). The ceiling is either 255 or the active compare value of channel A. A prescaler divides the system clock down to the timer tick rate.

Each channel compares the count against its own active compare value. The channel's output mode picks one of four behaviours: hold, toggle (channel A only), non-inverted level or inverted level. Compare values come from plain inputs. While a PWM mode runs, those inputs are copied into the active registers only when the counter turns at its ceiling, so the waveform is never cut mid-period. An overflow flag records each return to zero and stays set until a clear pulse arrives.

Top module: `pwm_timer8`

## Requirements
- R1: While reset is low, and right after it is released, the count is 0 and outA, outB and ovfFlag are all 0.
- R2: clkSel sets the tick rate: 1 divides by 1, 2 by 8, 3 by 64, 4 by 256 and 5 by 1024. The values 0, 6 and 7 stop the counter, which keeps its value.
- R3: waveMode 3 and 7 are fast PWM. On each tick the count goes up by one and wraps to 0 after the ceiling. The ceiling is 255 when waveMode bit 2 is 0, and the active compare A when bit 2 is 1.
- R4: In fast PWM, channel mode 2 drives the output to 1 exactly while the count is at or below the channel's active compare value, and mode 3 drives the inverse. A compare of 0 gives a single high tick per period. A compare of 255 with ceiling 255 gives a constant level.
- R5: waveMode 1 and 5 are phase-correct, with ceilings 255 and active compare A. The count rises to the ceiling, holds it for exactly one tick, then falls to 0, holds 0 for one tick and rises again.
- R6: In phase-correct mode, channel mode 2 drives the output to 1 exactly while the count is below the active compare value, and mode 3 drives the inverse. This gives 2k-1 high ticks per period for a compare value k≥1.
- R7: Channel mode 1 toggles outA on each tick where the count equals active compare A, but only when waveMode bit 2 is 1. Otherwise it holds outA. For outB, channel mode 1 always holds the output.
- R8: In the PWM modes, a new compare input moves into the active register only on the tick where the counter turns at its ceiling. When waveMode bit 0 is 0, the active registers follow the inputs on every clock.
- R9: ovfFlag sets on the tick where the count reaches 0: the wrap in fast PWM, or the step from 1 to 0 in phase-correct mode. It stays set until a one-cycle ovfClr pulse clears it, and a set in the same cycle wins.
- R10: A waveMode with bit 0 clear holds both the counter and the outputs. Channel mode 0 holds that channel's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clkSel | input | 3 | Prescaler select (0 stop, 1..5 divide by 1/8/64/256/1024) |
| waveMode | input | 3 | Waveform mode; bit 0 enables PWM, bit 1 selects fast, bit 2 selects ceiling from compare A |
| aMode | input | 2 | Channel A output mode (0 hold, 1 toggle, 2 normal, 3 inverted) |
| bMode | input | 2 | Channel B output mode (0 hold, 1 hold, 2 normal, 3 inverted) |
| cmpA | input | 8 | Compare value input for channel A |
| cmpB | input | 8 | Compare value input for channel B |
| ovfClr | input | 1 | Clears ovfFlag when pulsed high |
| outA | output | 1 | Channel A waveform |
| outB | output | 1 | Channel B waveform |
| count | output | 8 | Current counter value |
| ovfFlag | output | 1 | Sticky return-to-zero flag |

## Verification
The count, both outputs and the flag are registers that all update on the same clock edge as the tick that moves them. The bench therefore reads every result at the falling edge that follows the tick. Duty checks let the waveform settle for two full periods, then count the high samples over exactly one period, so the starting phase has no effect on the result. Ceiling turnaround, buffering, the flag and the divide ratios are checked by waiting for a given count value and then reading one falling edge later, or by counting cycles between successive count changes.

// File: rtl/pwm_timer8_pkg.sv
package pwm_timer8_pkg;
  localparam int CNT_W = 8;
  localparam int PRE_W = 10;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // strobes from control to datapath, valid for one clock
  typedef struct packed {
    logic             step;      // timer tick while a PWM mode is active
    logic             reload;    // counter turns at its ceiling on this step
    logic             bottom;    // counter lands on zero on this step
    logic             fast;      // single-slope counting
    logic [CNT_W-1:0] nextCount; // count value after this step
  } strobe_t;
endpackage

// File: rtl/pwm_timer8_ctrl.sv
module pwm_timer8_ctrl
  import pwm_timer8_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       clkSel,
  input  logic [2:0]       waveMode,
  input  logic [CNT_W-1:0] topCmp,
  output logic [CNT_W-1:0] count,
  output strobe_t          strb
);
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] divLast;
  logic             run;
  logic             tick;
  logic             countUp;
  logic             nextUp;
  logic [CNT_W-1:0] nextCount;
  logic [CNT_W-1:0] topVal;
  logic             atTop;
  logic             fastM;

  always_comb begin
    case (clkSel)
      3'd2:    divLast = PRE_W'(7);
      3'd3:    divLast = PRE_W'(63);
      3'd4:    divLast = PRE_W'(255);
      3'd5:    divLast = PRE_W'(1023);
      default: divLast = '0;
    endcase
  end

  assign run  = (clkSel != 3'd0) && (clkSel <= 3'd5);
  assign tick = run && (preCnt == divLast);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       preCnt <= '0;
    else if (!run)   preCnt <= '0;
    else if (tick)   preCnt <= '0;
    else             preCnt <= preCnt + 1'b1;
  end

  assign fastM  = waveMode[1];
  assign topVal = waveMode[2] ? topCmp : CNT_MAX;
  assign atTop  = (count >= topVal);

  always_comb begin
    nextCount = count;
    nextUp    = countUp;
    if (fastM) begin
      nextUp    = 1'b1;
      nextCount = atTop ? '0 : count + 1'b1;
    end else if (countUp) begin
      if (atTop) begin
        nextUp    = 1'b0;
        nextCount = (count == '0) ? '0 : count - 1'b1;
      end else begin
        nextCount = count + 1'b1;
      end
    end else begin
      if (count == '0) begin
        nextUp    = 1'b1;
        nextCount = (topVal == '0) ? '0 : CNT_W'(1);
      end else begin
        nextCount = count - 1'b1;
      end
    end
  end

  assign strb.step      = tick && waveMode[0];
  assign strb.reload    = atTop && (fastM || countUp);
  assign strb.bottom    = fastM ? atTop : (!countUp && count == CNT_W'(1));
  assign strb.fast      = fastM;
  assign strb.nextCount = nextCount;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count   <= '0;
      countUp <= 1'b1;
    end else if (strb.step) begin
      count   <= nextCount;
      countUp <= nextUp;
    end
  end
endmodule

// File: rtl/pwm_timer8_dp.sv
module pwm_timer8_dp
  import pwm_timer8_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             pwmOn,
  input  logic             topSel,
  input  logic [1:0]       aMode,
  input  logic [1:0]       bMode,
  input  logic [CNT_W-1:0] cmpA,
  input  logic [CNT_W-1:0] cmpB,
  input  logic             ovfClr,
  input  logic [CNT_W-1:0] count,
  input  strobe_t          strb,
  output logic [CNT_W-1:0] actA,
  output logic             outA,
  output logic             outB,
  output logic             ovfFlag
);
  localparam int N_CH = 2;

  logic [CNT_W-1:0] cmpIn [N_CH];
  logic [CNT_W-1:0] act   [N_CH];
  logic [1:0]       chMode[N_CH];
  logic [N_CH-1:0]  outV;

  assign cmpIn[0]  = cmpA;
  assign cmpIn[1]  = cmpB;
  assign chMode[0] = aMode;
  assign chMode[1] = bMode;

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_chan
    localparam bit CAN_TOGGLE = (ch == 0);
    logic level;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                         act[ch] <= '0;
      else if (!pwmOn)                   act[ch] <= cmpIn[ch];
      else if (strb.step && strb.reload) act[ch] <= cmpIn[ch];
    end

    assign level = strb.fast ? (strb.nextCount <= act[ch])
                             : (strb.nextCount <  act[ch]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) outV[ch] <= 1'b0;
      else if (strb.step) begin
        case (chMode[ch])
          2'd1: if (CAN_TOGGLE && topSel && count == act[ch]) outV[ch] <= ~outV[ch];
          2'd2: outV[ch] <= level;
          2'd3: outV[ch] <= ~level;
          default: outV[ch] <= outV[ch];
        endcase
      end
    end
  end

  assign actA = act[0];
  assign outA = outV[0];
  assign outB = outV[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         ovfFlag <= 1'b0;
    else if (strb.step && strb.bottom) ovfFlag <= 1'b1;
    else if (ovfClr)                   ovfFlag <= 1'b0;
  end
endmodule

// File: rtl/pwm_timer8.sv
module pwm_timer8
  import pwm_timer8_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       clkSel,
  input  logic [2:0]       waveMode,
  input  logic [1:0]       aMode,
  input  logic [1:0]       bMode,
  input  logic [CNT_W-1:0] cmpA,
  input  logic [CNT_W-1:0] cmpB,
  input  logic             ovfClr,
  output logic             outA,
  output logic             outB,
  output logic [CNT_W-1:0] count,
  output logic             ovfFlag
);
  strobe_t          strb;
  logic [CNT_W-1:0] actA;

  pwm_timer8_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .clkSel   (clkSel),
    .waveMode (waveMode),
    .topCmp   (actA),
    .count    (count),
    .strb     (strb)
  );

  pwm_timer8_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .pwmOn   (waveMode[0]),
    .topSel  (waveMode[2]),
    .aMode   (aMode),
    .bMode   (bMode),
    .cmpA    (cmpA),
    .cmpB    (cmpB),
    .ovfClr  (ovfClr),
    .count   (count),
    .strb    (strb),
    .actA    (actA),
    .outA    (outA),
    .outB    (outB),
    .ovfFlag (ovfFlag)
  );
endmodule

// File: rtl/pwm_timer8_chk.sv
module pwm_timer8_chk
  import pwm_timer8_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic [2:0]       clkSel,
  input logic [2:0]       waveMode,
  input logic [1:0]       aMode,
  input logic [1:0]       bMode,
  input logic             ovfClr,
  input logic             outA,
  input logic             outB,
  input logic [CNT_W-1:0] count,
  input logic             ovfFlag
);
  // R2
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clkSel == 3'd0) |=> $stable(count));

  // R10
  nonpwm_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!waveMode[0]) |=> ($stable(count) && $stable(outA) && $stable(outB)));

  // R7
  b_toggle_none_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bMode == 2'd1) |=> $stable(outB));

  // R7
  a_toggle_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (aMode == 2'd1 && !waveMode[2]) |=> $stable(outA));

  // R9
  ovf_at_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfFlag) |-> (count == '0));

  // R9
  ovf_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ovfFlag) |-> $past(ovfClr));
endmodule

bind pwm_timer8 pwm_timer8_chk u_chk (.*);

// File: tb/pwm_timer8_bench.sv
module pwm_timer8_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] clkSel = '0;
  logic [2:0] waveMode = '0;
  logic [1:0] aMode = '0;
  logic [1:0] bMode = '0;
  logic [7:0] cmpA = '0;
  logic [7:0] cmpB = '0;
  logic       ovfClr = 1'b0;
  logic       outA, outB, ovfFlag;
  logic [7:0] count;

  int nTests = 0;
  int nFail  = 0;

  always #10 clk = ~clk;

  pwm_timer8 u_pwm_timer8 (
    .clk(clk), .rstN(rstN), .clkSel(clkSel), .waveMode(waveMode),
    .aMode(aMode), .bMode(bMode), .cmpA(cmpA), .cmpB(cmpB),
    .ovfClr(ovfClr), .outA(outA), .outB(outB), .count(count),
    .ovfFlag(ovfFlag)
  );

  typedef struct packed {
    logic [2:0] mode;
    logic [1:0] am;
    logic [1:0] bm;
    logic [7:0] ca;
    logic [7:0] cb;
    int         per;
    int         hiA;
    int         hiB;
    int         req;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{3'd3, 2'd2, 2'd3, 8'd64,  8'd128, 256, 65,  127, 4}, // R4 normal / inverted
    '{3'd3, 2'd2, 2'd2, 8'd0,   8'd255, 256, 1,   256, 4}, // R4 spike and constant
    '{3'd3, 2'd3, 2'd3, 8'd255, 8'd0,   256, 0,   255, 4}, // R4 inverted extremes
    '{3'd1, 2'd2, 2'd3, 8'd100, 8'd10,  510, 199, 491, 6}, // R6 ceiling 255
    '{3'd1, 2'd2, 2'd2, 8'd0,   8'd255, 510, 0,   509, 6}, // R6 extremes
    '{3'd7, 2'd1, 2'd2, 8'd9,   8'd2,   20,  10,  6,   7}, // R7 toggle, R3 ceiling cmpA
    '{3'd7, 2'd1, 2'd0, 8'd0,   8'd0,   2,   1,   0,   7}, // R7 half tick rate, R10 hold
    '{3'd5, 2'd2, 2'd2, 8'd50,  8'd20,  100, 99,  39,  6}, // R6 ceiling cmpA
    '{3'd3, 2'd1, 2'd1, 8'd7,   8'd7,   256, 0,   0,   7}, // R7 toggle gated off
    '{3'd5, 2'd3, 2'd3, 8'd60,  8'd60,  120, 1,   1,   6}  // R6 inverted
  };

  task automatic check(input string req, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic restart(input logic [7:0] a, input logic [7:0] b);
    @(negedge clk);
    rstN = 1'b0; clkSel = 3'd0; waveMode = 3'd0; aMode = 2'd0; bMode = 2'd0;
    cmpA = a; cmpB = b; ovfClr = 1'b0;
    cyc(2);
    rstN = 1'b1;
    cyc(2);
  endtask

  task automatic waitCount(input logic [7:0] v);
    while (count != v) @(negedge clk);
  endtask

  task automatic gap(output int n);
    logic [7:0] c;
    c = count;
    while (count == c) @(negedge clk);
    c = count;
    n = 0;
    while (count == c) begin @(negedge clk); n++; end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    nTests++; nFail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin : main
    int hA, hB, n;
    logic [7:0] c0;
    logic a0;

    // R1 reset state
    cyc(2);
    check("R1 count in reset", count, 0);
    check("R1 outputs in reset", {outA, outB, ovfFlag}, 0);
    restart(8'd0, 8'd0);
    check("R1 after release", {count, outA, outB, ovfFlag}, 0);

    // table of waveform vectors
    for (int v = 0; v < NV; v++) begin
      restart(VECS[v].ca, VECS[v].cb);
      waveMode = VECS[v].mode; aMode = VECS[v].am; bMode = VECS[v].bm;
      clkSel = 3'd1;
      cyc(2 * VECS[v].per);
      hA = 0; hB = 0;
      for (int i = 0; i < VECS[v].per; i++) begin
        @(negedge clk);
        hA += int'(outA);
        hB += int'(outB);
      end
      check($sformatf("R%0d vec%0d outA highs", VECS[v].req, v), hA, VECS[v].hiA);
      check($sformatf("R%0d vec%0d outB highs", VECS[v].req, v), hB, VECS[v].hiB);
    end

    // R3 fast wrap at ceiling 255
    restart(8'd0, 8'd0);
    waveMode = 3'd3; clkSel = 3'd1;
    waitCount(8'd255); @(negedge clk);
    check("R3 wrap to zero", count, 0);

    // R2 divide ratios and stop
    clkSel = 3'd2; gap(n);
    check("R2 divide by 8", n, 8);
    clkSel = 3'd3; gap(n);
    check("R2 divide by 64", n, 64);
    clkSel = 3'd0; c0 = count; cyc(80);
    check("R2 stopped counter", count, int'(c0));
    clkSel = 3'd7; cyc(80);
    check("R2 reserved select stops", count, int'(c0));

    // R9 overflow flag
    restart(8'd0, 8'd0);
    waveMode = 3'd3; clkSel = 3'd1;
    waitCount(8'd255);
    check("R9 flag clear before wrap", ovfFlag, 0);
    @(negedge clk);
    check("R9 flag set at zero", ovfFlag, 1);
    waitCount(8'd5);
    check("R9 flag sticky", ovfFlag, 1);
    ovfClr = 1'b1; @(negedge clk); ovfClr = 1'b0;
    check("R9 flag cleared", ovfFlag, 0);

    // R8 buffered compare
    restart(8'd0, 8'd10);
    waveMode = 3'd3; bMode = 2'd2; clkSel = 3'd1;
    waitCount(8'd20);
    cmpB = 8'd200;
    waitCount(8'd100);
    check("R8 old compare still active", outB, 0);
    waitCount(8'd0); waitCount(8'd100);
    check("R8 new compare after ceiling", outB, 1);

    // R10 non-PWM mode holds counter and outputs
    waitCount(8'd150);
    waveMode = 3'd2; c0 = count; a0 = outB; cyc(40);
    check("R10 count held", count, int'(c0));
    check("R10 output held", outB, int'(a0));

    // R5 phase-correct turnaround
    restart(8'd5, 8'd0);
    waveMode = 3'd5; clkSel = 3'd1;
    waitCount(8'd5); @(negedge clk);
    check("R5 falls after single top tick", count, 4);
    waitCount(8'd0); @(negedge clk);
    check("R5 rises after single bottom tick", count, 1);

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule